// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block sits beside the command pins of a two-bank synchronous DRAM and only listens. On each rising clock edge it decodes the sampled command and updates a small state model for each bank. The bank states are idle, row open, reading, writing, reading with auto-close, writing with auto-close, and closing. It also keeps cycle counters for the minimum spacings between commands. When a command breaks the legality table for the bank it addresses, or arrives too early after an earlier command, the monitor raises a one-cycle error pulse with a 4-bit code. Tracking continues after any error.

The bank-address pin selects the target bank of activate, read, write and single-bank close commands. The precharge/auto-close pin has three uses. On activate it is the row-address MSB, so the monitor ignores it there. On read and write it requests auto-close. On a close command it turns a single-bank close into a close of both banks.

Integration is purely passive. The monitor's inputs are tapped from the memory controller's pins, and its error outputs go to a log or an interrupt collector.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: 0000 mode set, 0001 refresh, 0010 close (precharge), 0011 activate, 0100 write, 0101 read, 0110 burst stop, 0111 no-op. With cs_n high the command is a deselect. The error result of a command sampled at edge N appears on err_pulse/err_code after edge N and lasts one cycle. No-op, deselect and reset leave err_pulse at 0 and err_code at 0.
- R2: A command is ignored when cke was low at the edge before the one that samples it.
- R3: Read or write to an idle bank gives code 1 (illegal in state). Activate to an idle bank opens it.
- R4: bank_sel picks the bank for activate, read, write and single-bank close. A bank that was not addressed is not affected.
- R5: A close with a10 high closes both banks, whatever bank_sel says. With a10 low it closes only the selected bank. A close to an idle bank is accepted with no error.
- R6: A mode set is error-free only when both banks are idle. If an addressed bank is open, bursting or closing, the code is 6. Refresh to a non-idle bank gives code 1.
- R7: Read or write to an open bank fewer than T_RCD cycles after its activate gives code 2.
- R8: A close fewer than T_RAS cycles after the bank's activate gives code 3.
- R9: Activate to a bank fewer than T_RP cycles after its close gives code 4 and is rejected. At T_RP cycles or more the bank is idle again.
- R10: Activate fewer than T_RRD cycles after an accepted activate to the other bank gives code 5.
- R11: Two column commands fewer than T_CCD cycles apart give code 7. Activate to the same bank fewer than T_RC cycles after its previous activate gives code 8.
- R12: Read or write with a10 high locks the bank. Every command addressed to it other than no-op or deselect gives code 1 and is rejected. The bank becomes idle BURST_LEN+T_RP cycles after the command.
- R13: Commands that give code 1 or code 6 change no state. Commands with a timing code still take effect. When both banks report an error, the code of bank 0 is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable pin as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | BANK_BITS | Bank-address pin |
| a10 | input | 1 | Auto-close / close-all pin |
| err_pulse | output | 1 | One-cycle error strobe |
| err_code | output | 4 | Error code, 0 when no error |

## Verification
Directed command streams first probe the legality table. Reads and writes go to idle banks, commands go to the wrong bank, and commands are sent into an auto-close burst. These tests separate rejection by state from acceptance. Each minimum spacing is then hit both one cycle short and exactly on its limit. This shows whether a counter starts at the command's own edge, and it catches off-by-one comparisons. Close-all with a mismatched bank address, and a close that faults in both banks at once, show how a10 and bank_sel each act and which bank wins the error priority. A follow-up command then shows whether a rejected or a timing-faulted command changed state.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

   typedef enum logic [3:0] {
      C_DESL, C_NOP, C_BST, C_READ, C_WRIT, C_ACT, C_PRE, C_REF, C_MRS
   } cmd_e;

   typedef enum logic [2:0] {
      B_IDLE, B_ACTV, B_RD, B_WR, B_RDA, B_WRA, B_PRC
   } bank_st_e;

   typedef enum logic [3:0] {
      E_NONE    = 4'd0,
      E_ILLEGAL = 4'd1,
      E_TRCD    = 4'd2,
      E_TRAS    = 4'd3,
      E_TRP     = 4'd4,
      E_TRRD    = 4'd5,
      E_MRS     = 4'd6,
      E_TCCD    = 4'd7,
      E_TRC     = 4'd8
   } err_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_sat_cnt.sv
// Cycle counter: load sets it to 1, otherwise it counts up and sticks at all-ones.
module sdram_sat_cnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)          q <= '1;
      else if (load)       q <= W'(1);
      else if (q != '1)    q <= q + W'(1);
   end
endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_mon_pkg::*;
(
   input  logic cke_q,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e op
);
   always_comb begin
      if (!cke_q || cs_n) begin
         op = C_DESL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b000:  op = C_MRS;
            3'b001:  op = C_REF;
            3'b010:  op = C_PRE;
            3'b011:  op = C_ACT;
            3'b100:  op = C_WRIT;
            3'b101:  op = C_READ;
            3'b110:  op = C_BST;
            default: op = C_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
   import sdram_mon_pkg::*;
#(
   parameter int unsigned T_RCD     = 2,
   parameter int unsigned T_RAS     = 5,
   parameter int unsigned T_RP      = 2,
   parameter int unsigned T_RC      = 7,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned CW        = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  cmd_e op,
   input  logic hit,
   input  logic ap,
   input  logic rrd_ok,
   input  logic ccd_ok,
   output err_e err,
   output logic act_take,
   output logic col_take
);
   localparam logic [CW-1:0] L_RCD  = CW'(T_RCD);
   localparam logic [CW-1:0] L_RAS  = CW'(T_RAS);
   localparam logic [CW-1:0] L_RP   = CW'(T_RP);
   localparam logic [CW-1:0] L_RC   = CW'(T_RC);
   localparam logic [CW-1:0] L_BL   = CW'(BURST_LEN);
   localparam logic [CW-1:0] L_APRP = CW'(BURST_LEN + T_RP);

   bank_st_e        st, eff, nxt;
   logic [CW-1:0]   act_cnt, ph_cnt;
   logic            pre_take;

   // state after timed phases that have run out
   always_comb begin
      eff = st;
      unique case (st)
         B_PRC:        if (ph_cnt >= L_RP)   eff = B_IDLE;
         B_RD, B_WR:   if (ph_cnt >= L_BL)   eff = B_ACTV;
         B_RDA, B_WRA: if (ph_cnt >= L_APRP) eff = B_IDLE;
         default: ;
      endcase
   end

   function automatic bank_st_e burst_state(input cmd_e c, input logic auto);
      if (c == C_READ) return auto ? B_RDA : B_RD;
      return auto ? B_WRA : B_WR;
   endfunction

   always_comb begin
      err      = E_NONE;
      nxt      = eff;
      act_take = 1'b0;
      col_take = 1'b0;
      pre_take = 1'b0;
      if (hit) begin
         unique case (eff)
            B_IDLE: begin
               unique case (op)
                  C_ACT: begin
                     if (act_cnt < L_RC)  err = E_TRC;
                     else if (!rrd_ok)    err = E_TRRD;
                     nxt      = B_ACTV;
                     act_take = 1'b1;
                  end
                  C_READ, C_WRIT: err = E_ILLEGAL;
                  default: ;
               endcase
            end
            B_ACTV, B_RD, B_WR: begin
               unique case (op)
                  C_READ, C_WRIT: begin
                     if (eff == B_ACTV && act_cnt < L_RCD) err = E_TRCD;
                     else if (!ccd_ok)                     err = E_TCCD;
                     nxt      = burst_state(op, ap);
                     col_take = 1'b1;
                  end
                  C_PRE: begin
                     if (act_cnt < L_RAS) err = E_TRAS;
                     nxt      = B_PRC;
                     pre_take = 1'b1;
                  end
                  C_BST:        nxt = B_ACTV;
                  C_MRS:        err = E_MRS;
                  C_ACT, C_REF: err = E_ILLEGAL;
                  default: ;
               endcase
            end
            B_RDA, B_WRA: err = E_ILLEGAL;
            B_PRC: begin
               unique case (op)
                  C_ACT: err = E_TRP;
                  C_MRS: err = E_MRS;
                  C_READ, C_WRIT, C_PRE, C_REF: err = E_ILLEGAL;
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= B_IDLE;
      else        st <= nxt;
   end

   sdram_sat_cnt #(.W(CW)) u_act_cnt (
      .clk(clk), .rst_n(rst_n), .load(act_take), .q(act_cnt)
   );

   sdram_sat_cnt #(.W(CW)) u_ph_cnt (
      .clk(clk), .rst_n(rst_n), .load(col_take | pre_take), .q(ph_cnt)
   );

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdram_mon_pkg::*;
#(
   parameter int unsigned BANK_BITS = 1,
   parameter int unsigned T_RCD     = 2,
   parameter int unsigned T_RAS     = 5,
   parameter int unsigned T_RP      = 2,
   parameter int unsigned T_RC      = 7,
   parameter int unsigned T_RRD     = 2,
   parameter int unsigned T_CCD     = 2,
   parameter int unsigned BURST_LEN = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BANK_BITS-1:0] bank_sel,
   input  logic                 a10,
   output logic                 err_pulse,
   output logic [3:0]           err_code
);
   localparam int unsigned NUM_BANKS = 1 << BANK_BITS;
   localparam int unsigned CNT_MAX   =
      max2(max2(max2(T_RC, T_RAS), max2(T_RCD, T_RRD)), max2(T_CCD, BURST_LEN + T_RP));
   localparam int unsigned CW        = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] L_RRD   = CW'(T_RRD);
   localparam logic [CW-1:0] L_CCD   = CW'(T_CCD);

   if (BANK_BITS < 1 || BANK_BITS > 3) begin : g_bad_banks
      $error("BANK_BITS must lie in 1..3");
   end
   if (T_RCD < 1 || T_RAS < 1 || T_RP < 1 || T_RC < 1 || T_RRD < 1 || T_CCD < 1) begin : g_bad_timing
      $error("every minimum spacing must be at least one cycle");
   end
   if (BURST_LEN < 1) begin : g_bad_burst
      $error("BURST_LEN must be at least one");
   end

   logic                 cke_q;
   cmd_e                 op;
   logic [NUM_BANKS-1:0] hit, act_take, col_take, rrd_ok;
   err_e                 berr [NUM_BANKS];
   err_e                 sel_err;
   logic [CW-1:0]        rrd_cnt, ccd_cnt;
   logic [BANK_BITS-1:0] last_bank, act_bank;
   logic                 act_any, ccd_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) cke_q <= 1'b0;
      else        cke_q <= cke;
   end

   sdram_cmd_decode u_dec (
      .cke_q(cke_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .op(op)
   );

   assign ccd_ok = (ccd_cnt >= L_CCD);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic is_mine;
      assign is_mine = (bank_sel == BANK_BITS'(b));
      always_comb begin
         unique case (op)
            C_ACT, C_READ, C_WRIT: hit[b] = is_mine;
            C_PRE:                 hit[b] = a10 | is_mine;
            C_BST, C_REF, C_MRS:   hit[b] = 1'b1;
            default:               hit[b] = 1'b0;
         endcase
      end
      assign rrd_ok[b] = (last_bank == BANK_BITS'(b)) || (rrd_cnt >= L_RRD);

      sdram_bank_track #(
         .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC),
         .BURST_LEN(BURST_LEN), .CW(CW)
      ) u_trk (
         .clk(clk), .rst_n(rst_n), .op(op), .hit(hit[b]), .ap(a10),
         .rrd_ok(rrd_ok[b]), .ccd_ok(ccd_ok), .err(berr[b]),
         .act_take(act_take[b]), .col_take(col_take[b])
      );
   end

   always_comb begin
      act_any  = 1'b0;
      act_bank = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (act_take[b]) begin
            act_any  = 1'b1;
            act_bank = BANK_BITS'(b);
         end
      end
   end

   // lowest bank with a fault wins
   always_comb begin
      sel_err = E_NONE;
      for (int b = NUM_BANKS - 1; b >= 0; b--) begin
         if (berr[b] != E_NONE) sel_err = berr[b];
      end
   end

   sdram_sat_cnt #(.W(CW)) u_rrd_cnt (
      .clk(clk), .rst_n(rst_n), .load(act_any), .q(rrd_cnt)
   );

   sdram_sat_cnt #(.W(CW)) u_ccd_cnt (
      .clk(clk), .rst_n(rst_n), .load(|col_take), .q(ccd_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_bank <= '0;
         err_pulse <= 1'b0;
         err_code  <= 4'd0;
      end else begin
         if (act_any) last_bank <= act_bank;
         err_pulse <= (sel_err != E_NONE);
         err_code  <= sel_err;
      end
   end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic       cs_n,
   input logic       ras_n,
   input logic       cas_n,
   input logic       we_n,
   input logic       err_pulse,
   input logic [3:0] err_code
);
   logic cke_d, seen_act, col_fresh_q, mrs_fresh_q;
   logic live;

   assign live = cke_d && !cs_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_d       <= 1'b0;
         seen_act    <= 1'b0;
         col_fresh_q <= 1'b0;
         mrs_fresh_q <= 1'b0;
      end else begin
         cke_d       <= cke;
         if (live && !ras_n && cas_n && we_n) seen_act <= 1'b1;
         col_fresh_q <= live && ras_n && !cas_n && !seen_act;
         mrs_fresh_q <= live && !ras_n && !cas_n && !we_n && !seen_act;
      end
   end

   a_r1_desl_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> !err_pulse);

   a_r1_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cs_n && ras_n && cas_n && we_n) |-> !err_pulse);

   a_r2_suspend_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cke, 2) |-> !err_pulse);

   a_r3_column_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      col_fresh_q |-> (err_pulse && err_code == 4'd1));

   a_r6_mode_set_idle_ok: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_fresh_q |-> !err_pulse);

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
   .cas_n(cas_n), .we_n(we_n), .err_pulse(err_pulse), .err_code(err_code)
);

// File: tb/sdram_cmd_monitor_tb.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_tb;
   localparam logic [3:0] P_DESL = 4'b1111;
   localparam logic [3:0] P_NOP  = 4'b0111;
   localparam logic [3:0] P_BST  = 4'b0110;
   localparam logic [3:0] P_READ = 4'b0101;
   localparam logic [3:0] P_WRIT = 4'b0100;
   localparam logic [3:0] P_ACT  = 4'b0011;
   localparam logic [3:0] P_PRE  = 4'b0010;
   localparam logic [3:0] P_REF  = 4'b0001;
   localparam logic [3:0] P_MRS  = 4'b0000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [0:0] bank_sel = 1'b0;
   logic       a10 = 1'b0;
   logic       err_pulse;
   logic [3:0] err_code;
   int         n_chk = 0;
   int         n_err = 0;

   always #2 clk = ~clk;

   sdram_cmd_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .bank_sel(bank_sel), .a10(a10),
      .err_pulse(err_pulse), .err_code(err_code)
   );

   task automatic drive(input logic [3:0] pins, input int bank, input logic hi10);
      {cs_n, ras_n, cas_n, we_n} = pins;
      bank_sel = bank[0:0];
      a10      = hi10;
   endtask

   task automatic check(input int exp, input string tag);
      n_chk++;
      if (err_pulse !== (exp != 0) || err_code !== exp[3:0]) begin
         n_err++;
         $display("FAIL %s: err_pulse=%0b err_code=%0d, expected code %0d",
                  tag, err_pulse, err_code, exp);
      end
   endtask

   // drive one command for one cycle, then check its registered result
   task automatic step(input logic [3:0] pins, input int bank, input logic hi10,
                       input int exp, input string tag);
      drive(pins, bank, hi10);
      @(negedge clk);
      check(exp, tag);
   endtask

   task automatic idle(input int n);
      drive(P_NOP, 0, 1'b0);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cke   = 1'b1;
      drive(P_NOP, 0, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(0, "R1 reset state");
   endtask

   task automatic t_idle_bank();
      do_reset();
      step(P_READ, 0, 1'b0, 1, "R3 read to idle bank");
      step(P_WRIT, 1, 1'b1, 1, "R3 write-auto to idle bank");
      step(P_NOP,  0, 1'b0, 0, "R1 no-op");
      step(P_DESL, 0, 1'b0, 0, "R1 deselect");
      step(P_PRE,  0, 1'b0, 0, "R5 close idle bank");
      step(P_MRS,  0, 1'b0, 0, "R6 mode set all idle");
      step(P_REF,  0, 1'b0, 0, "R6 refresh all idle");
   endtask

   task automatic t_suspend();
      do_reset();
      cke = 1'b0;
      drive(P_NOP, 0, 1'b0);
      @(negedge clk);
      cke = 1'b1;
      step(P_READ, 0, 1'b0, 0, "R2 read ignored after cke low");
      step(P_READ, 0, 1'b0, 1, "R2 read seen after cke high");
   endtask

   task automatic t_bank_select();
      do_reset();
      step(P_ACT,  0, 1'b0, 0, "R3 open bank 0");
      step(P_ACT,  0, 1'b0, 1, "R13 activate open bank rejected");
      step(P_READ, 0, 1'b0, 0, "R13 rejected activate kept row timer");
      step(P_READ, 1, 1'b0, 1, "R4 other bank still idle");
   endtask

   task automatic t_rcd_ccd();
      do_reset();
      step(P_ACT,  0, 1'b0, 0, "R7 open bank 0");
      step(P_READ, 0, 1'b0, 2, "R7 read one cycle after activate");
      idle(1);
      step(P_READ, 0, 1'b0, 0, "R11 column gap at limit");
      step(P_READ, 0, 1'b0, 7, "R11 column gap short");
   endtask

   task automatic t_ras_rp_rc();
      do_reset();
      step(P_ACT, 1, 1'b0, 0, "R8 open bank 1");
      step(P_PRE, 1, 1'b0, 3, "R8 close too soon");
      step(P_ACT, 1, 1'b0, 4, "R9 activate during close");
      step(P_ACT, 1, 1'b0, 8, "R11 activate-to-activate short");
      idle(4);
      step(P_PRE, 1, 1'b0, 0, "R8 close at limit");
      idle(1);
      step(P_ACT, 1, 1'b0, 0, "R9 activate after close delay");
   endtask

   task automatic t_rrd();
      do_reset();
      step(P_ACT, 0, 1'b0, 0, "R10 open bank 0");
      step(P_ACT, 1, 1'b0, 5, "R10 other bank too soon");
      do_reset();
      step(P_ACT, 0, 1'b0, 0, "R10 open bank 0");
      idle(1);
      step(P_ACT, 1, 1'b0, 0, "R10 other bank at limit");
   endtask

   task automatic t_close_all();
      do_reset();
      step(P_ACT, 0, 1'b0, 0, "R5 open bank 0");
      idle(1);
      step(P_ACT, 1, 1'b0, 0, "R5 open bank 1");
      idle(4);
      step(P_PRE, 1, 1'b1, 0, "R5 close both, bank_sel=1");
      step(P_ACT, 0, 1'b0, 4, "R5 bank 0 closed by close-all");
      step(P_ACT, 1, 1'b0, 0, "R5 bank 1 idle after close-all");
      step(P_PRE, 0, 1'b0, 0, "R5 single close bank 0");
      step(P_READ, 1, 1'b0, 0, "R4 single close spared bank 1");
   endtask

   task automatic t_mode_set();
      do_reset();
      step(P_ACT, 0, 1'b0, 0, "R6 open bank 0");
      step(P_MRS, 0, 1'b0, 6, "R6 mode set with open bank");
      step(P_REF, 0, 1'b0, 1, "R6 refresh with open bank");
   endtask

   task automatic t_auto_close();
      do_reset();
      step(P_ACT,  0, 1'b0, 0, "R12 open bank 0");
      idle(1);
      step(P_WRIT, 0, 1'b1, 0, "R12 write with auto-close");
      step(P_READ, 0, 1'b0, 1, "R12 read during lock");
      step(P_PRE,  0, 1'b0, 1, "R12 close during lock");
      step(P_BST,  0, 1'b0, 1, "R12 burst stop during lock");
      idle(1);
      step(P_ACT,  0, 1'b0, 1, "R12 activate one cycle early");
      step(P_ACT,  0, 1'b0, 0, "R12 activate once idle");
      idle(1);
      step(P_READ, 0, 1'b1, 0, "R12 read with auto-close");
      step(P_MRS,  0, 1'b0, 1, "R12 mode set during lock");
   endtask

   task automatic t_priority();
      do_reset();
      step(P_ACT,  1, 1'b0, 0, "R13 open bank 1");
      idle(1);
      step(P_WRIT, 1, 1'b1, 0, "R13 bank 1 auto-close write");
      step(P_ACT,  0, 1'b0, 0, "R13 open bank 0");
      step(P_PRE,  0, 1'b1, 3, "R13 bank 0 code wins");
      step(P_ACT,  0, 1'b0, 4, "R13 timing fault still closed bank 0");
   endtask

   initial begin
      #(4 * 20000);
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      t_idle_bank();
      t_suspend();
      t_bank_select();
      t_rcd_ccd();
      t_ras_rp_rc();
      t_rrd();
      t_close_all();
      t_mode_set();
      t_auto_close();
      t_priority();
      idle(2);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule